// File: doc/BRIEF.md
# Shared I2C Engine Ownership Arbiter

This block decides who may drive a single shared I2C engine at any moment. Three parties compete for it: a software agent, a hardware agent and a microcontroller. Software asks for the engine with a request strobe and hands it back with a done strobe. The hardware agent has a request and a release strobe. A mode input reserves the engine for the microcontroller. A two-bit status word tells every party who owns the engine.

Hardware has the higher priority and may take the engine away from software in the middle of a batch. When that happens the block sends a one-cycle pre-emption pulse toward the engine and keeps a record of the interrupted batch. When hardware releases the engine, ownership goes back to software. The interrupted batch is then either restarted, with a one-cycle restart pulse, or dropped and flagged as aborted. A no-queued-start option input selects which of the two happens.

The controller has four states, each with its own transitions:
- **ST_IDLE**: goes to ST_HW on a hardware request, and to ST_SW on a software request when the microcontroller reservation is clear.
- **ST_SW**: goes to ST_HW_PRE on a hardware request, and to ST_IDLE on software done.
- **ST_HW**: goes to ST_IDLE on a hardware release.
- **ST_HW_PRE** (hardware owns the engine while a software claim is parked): goes to ST_SW on a hardware release, to ST_HW on software done, and to ST_IDLE when both arrive together.

Top module: `own_arbiter`

## Requirements
- R1: `own_status` reads 2'b00 for idle, 2'b01 for software owner and 2'b10 for hardware owner. It reads 2'b11 when the engine is idle and `mcu_only` is high. After reset it reads 2'b00.
- R2: A `sw_req` pulse from idle, with `hw_req` low and `mcu_only` low, makes the status 2'b01 after the next clock edge. From a hardware-owned state the same pulse leaves the status unchanged.
- R3: A `sw_req` pulse while software already owns the engine keeps the status at 2'b01 and leaves `sw_busy` unchanged.
- R4: A `sw_done` pulse while software owns the engine (no `hw_req`) returns the status to idle and clears `sw_busy` and `sw_abort`.
- R5: While `mcu_only` is high, `sw_req` from idle is refused and the status stays 2'b11.
- R6: `hw_req` takes the engine from idle or from software at any time. When `hw_req` and `sw_req` arrive in the same cycle from idle, hardware wins.
- R7: `hw_rel` returns the engine to idle, or to software (status 2'b01) if software was pre-empted and has not given up its claim.
- R8: Taking the engine from software raises `preempt` for exactly the one cycle after the takeover edge.
- R9: With `no_queued_go` low at the release edge, a pre-empted busy batch resumes: `sw_restart` pulses for one cycle while `sw_busy` stays high.
- R10: With `no_queued_go` high at the release edge, a pre-empted busy batch is dropped: `sw_busy` clears and `sw_abort` sets. `sw_abort` stays set until an accepted `sw_go` or a `sw_done`.
- R11: `sw_go` starts a batch (`sw_busy` high) only while software owns the engine and `hw_req` is low in that cycle. `eng_done` ends the batch only while software owns the engine.
- R12: A `sw_done` pulse while pre-empted drops the software claim. Hardware keeps the engine, and its later release leads to idle with no restart.
- R13: `hw_active` is high exactly while hardware owns the engine, whether it took the engine from idle or from software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Software ownership request strobe |
| sw_done | input | 1 | Software release strobe |
| sw_go | input | 1 | Software batch start strobe |
| eng_done | input | 1 | Engine reports that the software batch has finished |
| hw_req | input | 1 | Hardware agent request strobe |
| hw_rel | input | 1 | Hardware agent release strobe |
| mcu_only | input | 1 | Reserves the engine for the microcontroller |
| no_queued_go | input | 1 | 1: drop interrupted batch; 0: restart it |
| own_status | output | 2 | Ownership status (encoding in R1) |
| hw_active | output | 1 | Hardware owns the engine |
| preempt | output | 1 | One-cycle pre-emption pulse toward the engine |
| sw_restart | output | 1 | One-cycle restart pulse for the resumed batch |
| sw_abort | output | 1 | Interrupted batch was dropped |
| sw_busy | output | 1 | A software batch is in flight or parked |

## Verification
The key collision is a hardware request that arrives in the same cycle as a software command. A software request from idle or a batch start during software ownership are the main cases. The same goes for a hardware release that coincides with a software done while the software claim is parked. The bench sweeps all 256 combinations of the eight inputs from five prepared states. These states are idle, software busy, hardware only, parked busy, and software with the abort flag set. Each cycle it compares every output against a model computed from the requirements, which fixes hardware as the winner of each tie.

// File: rtl/own_arb_pkg.sv
package own_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SW     = 2'd1,
        ST_HW     = 2'd2,
        ST_HW_PRE = 2'd3
    } own_state_t;

    localparam int unsigned OWN_W = 2;

    localparam logic [OWN_W-1:0] OWN_IDLE = 2'b00;
    localparam logic [OWN_W-1:0] OWN_SW   = 2'b01;
    localparam logic [OWN_W-1:0] OWN_HW   = 2'b10;
    localparam logic [OWN_W-1:0] OWN_MCU  = 2'b11;

    typedef struct packed {
        logic takeover;   // hardware takes engine from software this cycle
        logic resume;     // parked software claim gets engine back this cycle
        logic sw_cmd_ok;  // software owns and no hardware request this cycle
        logic parked;     // hardware owns while software claim is parked
    } own_evt_t;

endpackage

// File: rtl/own_arb_fsm.sv
module own_arb_fsm
    import own_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req,
    input  logic       sw_done,
    input  logic       hw_req,
    input  logic       hw_rel,
    input  logic       mcu_only,
    output own_state_t state_q,
    output own_evt_t   evt
);

    own_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hw_req)                    state_d = ST_HW;
                else if (sw_req && !mcu_only)  state_d = ST_SW;
            end
            ST_SW: begin
                if (hw_req)       state_d = ST_HW_PRE;
                else if (sw_done) state_d = ST_IDLE;
            end
            ST_HW: begin
                if (hw_rel) state_d = ST_IDLE;
            end
            ST_HW_PRE: begin
                if (hw_rel && sw_done) state_d = ST_IDLE;
                else if (hw_rel)       state_d = ST_SW;
                else if (sw_done)      state_d = ST_HW;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        evt           = '0;
        evt.takeover  = (state_q == ST_SW) && hw_req;
        evt.sw_cmd_ok = (state_q == ST_SW) && !hw_req;
        evt.parked    = (state_q == ST_HW_PRE);
        evt.resume    = (state_q == ST_HW_PRE) && hw_rel && !sw_done;
    end

    a_r6_hw_takes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hw_req) |=> (state_q == ST_HW));

    a_r6_hw_preempts_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SW && hw_req) |=> (state_q == ST_HW_PRE));

    a_r2_sw_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sw_req && !hw_req && !mcu_only) |=> (state_q == ST_SW));

    a_r5_mcu_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mcu_only) |=> (state_q != ST_SW));

    a_r4_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SW && sw_done && !hw_req) |=> (state_q == ST_IDLE));

    a_r3_sw_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SW && sw_req && !sw_done && !hw_req) |=> (state_q == ST_SW));

    a_r12_quit_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HW_PRE && sw_done && !hw_rel) |=> (state_q == ST_HW));

endmodule

// File: rtl/own_arb_batch.sv
module own_arb_batch
    import own_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  own_evt_t evt,
    input  logic     sw_done,
    input  logic     sw_go,
    input  logic     eng_done,
    input  logic     no_queued_go,
    output logic     busy_q,
    output logic     restart_q,
    output logic     abort_q,
    output logic     preempt_q
);

    logic busy_d, restart_d, abort_d, preempt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            restart_q <= 1'b0;
            abort_q   <= 1'b0;
            preempt_q <= 1'b0;
        end else begin
            busy_q    <= busy_d;
            restart_q <= restart_d;
            abort_q   <= abort_d;
            preempt_q <= preempt_d;
        end
    end

    always_comb begin
        busy_d    = 1'b0;
        restart_d = 1'b0;
        abort_d   = abort_q;
        preempt_d = evt.takeover;
        if (evt.sw_cmd_ok) begin
            if (sw_done) begin
                abort_d = 1'b0;
            end else if (sw_go) begin
                busy_d  = 1'b1;
                abort_d = 1'b0;
            end else if (!eng_done) begin
                busy_d  = busy_q;
            end
        end else if (evt.takeover) begin
            busy_d = busy_q;
        end else if (evt.parked) begin
            if (sw_done) begin
                abort_d = 1'b0;
            end else if (evt.resume) begin
                if (busy_q && no_queued_go) begin
                    abort_d = 1'b1;
                end else if (busy_q) begin
                    restart_d = 1'b1;
                    busy_d    = 1'b1;
                end
            end else begin
                busy_d = busy_q;
            end
        end
    end

    a_r9_restart_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> busy_q);

    a_r10_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_q) |-> (!busy_q && !restart_q));

    a_r8_preempt_single: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_q |=> !preempt_q);

endmodule

// File: rtl/own_arb_status.sv
module own_arb_status
    import own_arb_pkg::*;
(
    input  own_state_t       state_q,
    input  logic             mcu_only,
    output logic [OWN_W-1:0] own_status,
    output logic             hw_active
);

    always_comb begin
        own_status = OWN_IDLE;
        hw_active  = 1'b0;
        unique case (state_q)
            ST_IDLE:   own_status = mcu_only ? OWN_MCU : OWN_IDLE;
            ST_SW:     own_status = OWN_SW;
            ST_HW:     begin own_status = OWN_HW; hw_active = 1'b1; end
            ST_HW_PRE: begin own_status = OWN_HW; hw_active = 1'b1; end
            default:   own_status = OWN_IDLE;
        endcase
    end

endmodule

// File: rtl/own_arbiter.sv
module own_arbiter
    import own_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req,
    input  logic       sw_done,
    input  logic       sw_go,
    input  logic       eng_done,
    input  logic       hw_req,
    input  logic       hw_rel,
    input  logic       mcu_only,
    input  logic       no_queued_go,
    output logic [1:0] own_status,
    output logic       hw_active,
    output logic       preempt,
    output logic       sw_restart,
    output logic       sw_abort,
    output logic       sw_busy
);

    own_state_t state_q;
    own_evt_t   evt;

    own_arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_req   (sw_req),
        .sw_done  (sw_done),
        .hw_req   (hw_req),
        .hw_rel   (hw_rel),
        .mcu_only (mcu_only),
        .state_q  (state_q),
        .evt      (evt)
    );

    own_arb_batch u_batch (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .sw_done      (sw_done),
        .sw_go        (sw_go),
        .eng_done     (eng_done),
        .no_queued_go (no_queued_go),
        .busy_q       (sw_busy),
        .restart_q    (sw_restart),
        .abort_q      (sw_abort),
        .preempt_q    (preempt)
    );

    own_arb_status u_status (
        .state_q    (state_q),
        .mcu_only   (mcu_only),
        .own_status (own_status),
        .hw_active  (hw_active)
    );

    a_r8_preempt_with_hw: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> hw_active);

    a_r11_busy_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy |-> (own_status == OWN_SW || hw_active));

    a_r7_release_clears_hw: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_active && hw_rel) |=> !hw_active);

endmodule

// File: tb/sim_own_arbiter.sv
module sim_own_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_req = 0, sw_done = 0, sw_go = 0, eng_done = 0;
    logic hw_req = 0, hw_rel = 0, mcu_only = 0, no_queued_go = 0;
    logic [1:0] own_status;
    logic hw_active, preempt, sw_restart, sw_abort, sw_busy;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model: 0 idle, 1 software, 2 hardware, 3 hardware with parked software claim
    int m_st = 0;
    bit m_busy = 0, m_rs = 0, m_ab = 0, m_pre = 0;

    always #5 clk = ~clk;

    own_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_done(sw_done),
        .sw_go(sw_go), .eng_done(eng_done), .hw_req(hw_req), .hw_rel(hw_rel),
        .mcu_only(mcu_only), .no_queued_go(no_queued_go),
        .own_status(own_status), .hw_active(hw_active), .preempt(preempt),
        .sw_restart(sw_restart), .sw_abort(sw_abort), .sw_busy(sw_busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        int exp_st;
        exp_st = (m_st == 0) ? (mcu_only ? 3 : 0) : (m_st == 1 ? 1 : 2);
        chk(tag, "own_status", int'(own_status), exp_st);
        chk(tag, "hw_active", int'(hw_active), int'(m_st >= 2));
        chk(tag, "preempt", int'(preempt), int'(m_pre));
        chk(tag, "sw_restart", int'(sw_restart), int'(m_rs));
        chk(tag, "sw_abort", int'(sw_abort), int'(m_ab));
        chk(tag, "sw_busy", int'(sw_busy), int'(m_busy));
    endtask

    // v: [0]sw_req [1]sw_done [2]sw_go [3]eng_done [4]hw_req [5]hw_rel [6]mcu_only [7]no_queued_go
    task automatic step(input logic [7:0] v, input string tag);
        int n_st;
        bit n_busy, n_rs, n_ab, n_pre;
        @(negedge clk);
        {no_queued_go, mcu_only, hw_rel, hw_req, eng_done, sw_go, sw_done, sw_req} = v;
        n_st = m_st; n_busy = 0; n_rs = 0; n_ab = m_ab; n_pre = 0;
        case (m_st)
            0: begin
                if (v[4]) n_st = 2;
                else if (v[0] && !v[6]) n_st = 1;
            end
            1: begin
                if (v[4]) begin n_st = 3; n_pre = 1; n_busy = m_busy; end
                else if (v[1]) begin n_st = 0; n_ab = 0; end
                else if (v[2]) begin n_busy = 1; n_ab = 0; end
                else if (!v[3]) n_busy = m_busy;
            end
            2: if (v[5]) n_st = 0;
            default: begin
                if (v[1]) begin n_ab = 0; n_st = v[5] ? 0 : 2; end
                else if (v[5]) begin
                    n_st = 1;
                    if (m_busy && v[7]) n_ab = 1;
                    else if (m_busy) begin n_rs = 1; n_busy = 1; end
                end else n_busy = m_busy;
            end
        endcase
        @(posedge clk);
        #1;
        m_st = n_st; m_busy = n_busy; m_rs = n_rs; m_ab = n_ab; m_pre = n_pre;
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {no_queued_go, mcu_only, hw_rel, hw_req, eng_done, sw_go, sw_done, sw_req} = '0;
        @(posedge clk);
        #1;
        m_st = 0; m_busy = 0; m_rs = 0; m_ab = 0; m_pre = 0;
        compare_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic prepare(input int s);
        do_reset();
        case (s)
            1: begin step(8'h01, "R2 prep"); step(8'h04, "R11 prep"); end
            2: step(8'h10, "R6 prep");
            3: begin step(8'h01, "R2 prep"); step(8'h04, "R11 prep"); step(8'h10, "R8 prep"); end
            4: begin
                step(8'h01, "R2 prep"); step(8'h04, "R11 prep");
                step(8'h10, "R8 prep"); step(8'hA0, "R10 prep");
            end
            default: ;
        endcase
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state and encoding including microcontroller-only idle
        do_reset();
        step(8'h40, "R1 mcu idle");
        step(8'h00, "R1 idle");

        // R2 grant from idle, R3 repeat request is a no-op
        step(8'h01, "R2 grant");
        step(8'h04, "R11 go");
        step(8'h01, "R3 re-request");
        step(8'h08, "R11 eng done");
        step(8'h02, "R4 release");

        // R5 microcontroller-only refuses software
        step(8'h41, "R5 refuse");
        step(8'h40, "R5 hold");

        // R6 same-cycle tie from idle: hardware wins; R13 hw_active
        step(8'h11, "R6 tie");
        step(8'h01, "R2 refused while hw");
        step(8'h20, "R7 release to idle");

        // R9 restart after pre-emption with option clear
        step(8'h01, "R2 grant");
        step(8'h04, "R11 go");
        step(8'h14, "R11 go lost to hw");
        step(8'h00, "R8 pulse ends");
        step(8'h20, "R9 restart");
        step(8'h00, "R9 pulse ends");

        // R10 drop after pre-emption with option set, then cleared by go
        step(8'h10, "R13 preempt");
        step(8'hA0, "R10 abort");
        step(8'h80, "R10 sticky");
        step(8'h04, "R10 cleared by go");

        // R12 software quits while parked
        step(8'h10, "R12 preempt");
        step(8'h02, "R12 quit");
        step(8'h20, "R12 release idle");

        // near-exhaustive sweep: every input combination from five prepared states
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 256; c++) begin
                prepare(s);
                step(c[7:0], "R1 sweep");
                step(8'h00, "R1 sweep settle");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule